// File: doc/BRIEF.md
# Four-Channel Buffered PWM Timer

This block is a 16-bit timer that drives four single-slope pulse-width waveforms from one shared counter. Software programs a period and four compare values through a simple write port. A read port returns the control state, the flags, the live counter and the active period and compare values. The counter can run upward or downward and is paced by a power-of-two clock divider.

New period and compare values go into buffer registers. They reach the active registers only when the counter wraps, so a duty change never takes effect in the middle of a PWM cycle. Each channel raises a sticky flag when the counter meets its compare value. The flag gives an interrupt request when that channel's interrupt enable is set.

Top module: `pwm4_timer`

## Requirements
- R1: After reset the counter, control word, channel enables, interrupt enables, flags, active period and active compares are all 0, so `pwm` and `irq` are low. Reset leaves the counter counting up with a divide of 1 and stopped.
- R2: With control bit 1 clear, each tick moves the counter up by one. A tick taken with the counter at or above the active period P loads 0, so a cycle lasts P+1 ticks.
- R3: With control bit 1 set, each tick moves the counter down by one. A tick taken at 0 loads the period that becomes active at that same wrap.
- R4: Ticks occur only while control bit 0 (run) is set. Control bits 3:2 hold a select s, and a tick comes once every 2^s clocks, counted from the clock edge that sets run. A write to address 4 loads the counter and takes priority over a tick.
- R5: A write to address 5 fills the period buffer. Address 5 reads the active period, which changes only on a wrap tick and only when the buffer was written since the last transfer.
- R6: Writes to addresses 6 to 9 fill the compare buffers of channels 0 to 3. Addresses 6 to 9 read the active compares, which follow the same wrap-only transfer rule as the period.
- R7: `pwm[i]` is high exactly when channel i is enabled (bit i at address 1) and the counter is below the active compare i. A compare of 0 therefore holds the line low, and a compare above the period holds it high.
- R8: A tick taken while the counter equals the active compare i sets flag i. `irq[i]` equals flag i ANDed with interrupt enable i (bit i at address 2).
- R9: A write to address 3 clears each flag whose data bit is 1 and leaves the others unchanged. A flag set in the same cycle as its clear stays set.
- R10: The read port returns the following. Address 0 gives the control word {select, direction, run} in bits 3:0. Addresses 1, 2 and 3 give the channel enables, the interrupt enables and the flags. Address 4 gives the counter. Any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (4) | Write address |
| wr_data | input | W (16) | Write data |
| rd_addr | input | AW (4) | Read address |
| rd_data | output | W (16) | Read data, combinational |
| pwm | output | NCH (4) | PWM waveforms |
| irq | output | NCH (4) | Per-channel interrupt requests |

## Verification
A corrupted counter shows on the read port and on every `pwm` edge within one tick. A wrong wrap decision stretches or shortens the next cycle, and that is visible on the following tick. A buffer transferred at the wrong time shows up immediately at the active-value read addresses, and from then on in the duty of the affected line. Flag faults show on `irq` one clock after the matching tick. The bench runs a cycle-by-cycle model alongside the design, so any of these divergences is caught in the cycle it first reaches a port.

// File: rtl/pwm4_timer.sv
module pwm4_timer #(
  parameter int W   = 16,
  parameter int NCH = 4,
  parameter int AW  = 4,
  parameter int PSW = 2
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [W-1:0]   wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [W-1:0]   rd_data,
  output logic [NCH-1:0] pwm,
  output logic [NCH-1:0] irq
);
  localparam int PCW = (1 << PSW) - 1;
  localparam int CW  = PSW + 2;
  localparam logic [AW-1:0] A_CTRL  = AW'(0);
  localparam logic [AW-1:0] A_CHEN  = AW'(1);
  localparam logic [AW-1:0] A_IRQEN = AW'(2);
  localparam logic [AW-1:0] A_FLAG  = AW'(3);
  localparam logic [AW-1:0] A_CNT   = AW'(4);
  localparam logic [AW-1:0] A_PER   = AW'(5);
  localparam int A_CMP0 = 6;

  logic           run, down;
  logic [PSW-1:0] psel;
  logic [NCH-1:0] chen, irqen, flag, hit, cmp_vld;
  logic [W-1:0]   cnt, per_act, per_buf;
  logic           per_vld;
  logic [NCH-1:0][W-1:0] cmp_act, cmp_buf;
  logic [PCW-1:0] pre, pmask;
  logic [PCW:0]   one_sh;

  assign one_sh = (PCW+1)'(1) << psel;
  assign pmask  = one_sh[PCW-1:0] - 1'b1;

  wire           tick   = run && ((pre & pmask) == pmask);
  wire           at_end = down ? (cnt == '0) : (cnt >= per_act);
  wire           wrap   = tick && at_end;
  wire           wr_cnt = wr_en && (wr_addr == A_CNT);
  wire           wr_per = wr_en && (wr_addr == A_PER);
  wire [W-1:0]   per_nx = per_vld ? per_buf : per_act;
  wire [NCH-1:0] clr    = (wr_en && wr_addr == A_FLAG) ? wr_data[NCH-1:0] : '0;

  assign irq = flag & irqen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {psel, down, run} <= '0;
      chen  <= '0;
      irqen <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:  {psel, down, run} <= wr_data[CW-1:0];
        A_CHEN:  chen  <= wr_data[NCH-1:0];
        A_IRQEN: irqen <= wr_data[NCH-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre  <= '0;
      cnt  <= '0;
      flag <= '0;
    end else begin
      pre  <= run ? pre + 1'b1 : '0;
      flag <= (flag & ~clr) | hit;
      if (wr_cnt)
        cnt <= wr_data;
      else if (tick) begin
        if (at_end) cnt <= down ? per_nx : '0;
        else        cnt <= down ? cnt - 1'b1 : cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_act <= '0;
      per_buf <= '0;
      per_vld <= 1'b0;
    end else begin
      if (wrap && per_vld) per_act <= per_buf;
      if (wr_per) begin
        per_buf <= wr_data;
        per_vld <= 1'b1;
      end else if (wrap)
        per_vld <= 1'b0;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    wire cw = wr_en && (wr_addr == AW'(A_CMP0 + g));
    assign hit[g] = tick && (cnt == cmp_act[g]);
    assign pwm[g] = chen[g] && (cnt < cmp_act[g]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_act[g] <= '0;
        cmp_buf[g] <= '0;
        cmp_vld[g] <= 1'b0;
      end else begin
        if (wrap && cmp_vld[g]) cmp_act[g] <= cmp_buf[g];
        if (cw) begin
          cmp_buf[g] <= wr_data;
          cmp_vld[g] <= 1'b1;
        end else if (wrap)
          cmp_vld[g] <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:  rd_data = W'({psel, down, run});
      A_CHEN:  rd_data = W'(chen);
      A_IRQEN: rd_data = W'(irqen);
      A_FLAG:  rd_data = W'(flag);
      A_CNT:   rd_data = cnt;
      A_PER:   rd_data = per_act;
      default: ;
    endcase
    for (int i = 0; i < NCH; i++)
      if (rd_addr == AW'(A_CMP0 + i)) rd_data = cmp_act[i];
  end
endmodule

// File: rtl/pwm4_timer_chk.sv
module pwm4_timer_chk #(
  parameter int W   = 16,
  parameter int NCH = 4
)(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tick,
  input logic                  down,
  input logic                  wr_cnt,
  input logic                  flag_wr,
  input logic [NCH-1:0]        clr_bits,
  input logic [W-1:0]          cnt,
  input logic [W-1:0]          per_act,
  input logic [NCH-1:0][W-1:0] cmp_act,
  input logic [NCH-1:0]        flag
);
  logic boundary;
  assign boundary = down ? (cnt == '0) : (cnt >= per_act);

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !down && !wr_cnt && cnt < per_act) |=> cnt == W'($past(cnt) + 1'b1)); // R2
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && down && !wr_cnt && cnt != '0) |=> cnt == W'($past(cnt) - 1'b1)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_cnt) |=> $stable(cnt)); // R4
  AST_PER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && boundary) |=> $stable(per_act)); // R5
  AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && boundary) |=> $stable(cmp_act)); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> ((flag & $past(flag)) == $past(flag))); // R9
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && ((flag & clr_bits) == '0)) |=> ((flag & $past(flag)) == $past(flag))); // R9
endmodule

bind pwm4_timer pwm4_timer_chk #(.W(W), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .down(down), .wr_cnt(wr_cnt),
  .flag_wr(wr_en && wr_addr == A_FLAG), .clr_bits(wr_data[NCH-1:0]),
  .cnt(cnt), .per_act(per_act), .cmp_act(cmp_act), .flag(flag)
);

// File: tb/sim_pwm4_timer.sv
module sim_pwm4_timer;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [3:0] pwm, irq;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwm4_timer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pwm(pwm), .irq(irq));

  int m_cnt, m_per, m_pbuf, m_ps, m_pre;
  int m_cmp[4], m_cbuf[4];
  bit m_pvld, m_run, m_dn;
  bit [3:0] m_cvld, m_chen, m_irqen, m_flag;

  function automatic int exp_rd(int a);
    case (a)
      0: return {m_ps[1:0], m_dn, m_run};
      1: return m_chen;
      2: return m_irqen;
      3: return m_flag;
      4: return m_cnt;
      5: return m_per;
      6, 7, 8, 9: return m_cmp[a-6];
      default: return 0;
    endcase
  endfunction

  function automatic bit [3:0] exp_pwm();
    bit [3:0] p;
    for (int i = 0; i < 4; i++) p[i] = m_chen[i] && (m_cnt < m_cmp[i]);
    return p;
  endfunction

  always @(posedge clk) begin
    int mask, ncnt, nper, d;
    bit tk, en, wp, w;
    bit [3:0] hit, clr;
    if (!rst_n) begin
      m_cnt = 0; m_per = 0; m_pbuf = 0; m_ps = 0; m_pre = 0;
      m_pvld = 0; m_run = 0; m_dn = 0; m_cvld = 0; m_chen = 0; m_irqen = 0; m_flag = 0;
      for (int i = 0; i < 4; i++) begin m_cmp[i] = 0; m_cbuf[i] = 0; end
    end else begin
      w = wr_en; d = wr_data;
      mask = (1 << m_ps) - 1;
      tk = m_run && ((m_pre & mask) == mask);
      en = m_dn ? (m_cnt == 0) : (m_cnt >= m_per);
      wp = tk && en;
      for (int i = 0; i < 4; i++) hit[i] = tk && (m_cnt == m_cmp[i]);
      clr = (w && wr_addr == 3) ? wr_data[3:0] : 4'h0;
      nper = m_pvld ? m_pbuf : m_per;
      ncnt = m_cnt;
      if (w && wr_addr == 4) ncnt = d;
      else if (tk) begin
        if (en) ncnt = m_dn ? nper : 0;
        else    ncnt = (m_dn ? m_cnt - 1 : m_cnt + 1) & 16'hFFFF;
      end
      m_pre = m_run ? ((m_pre + 1) & 7) : 0;
      if (wp && m_pvld) m_per = m_pbuf;
      if (w && wr_addr == 5) begin m_pbuf = d; m_pvld = 1; end
      else if (wp) m_pvld = 0;
      for (int i = 0; i < 4; i++) begin
        if (wp && m_cvld[i]) m_cmp[i] = m_cbuf[i];
        if (w && wr_addr == 4'(6 + i)) begin m_cbuf[i] = d; m_cvld[i] = 1; end
        else if (wp) m_cvld[i] = 0;
      end
      m_flag = (m_flag & ~clr) | hit;
      m_cnt = ncnt;
      if (w && wr_addr == 0) begin m_run = d[0]; m_dn = d[1]; m_ps = (d >> 2) & 3; end
      if (w && wr_addr == 1) m_chen = d[3:0];
      if (w && wr_addr == 2) m_irqen = d[3:0];
    end
  end

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R7 pwm vs model", pwm, exp_pwm());
      chk("R8 irq vs model", irq, m_flag & m_irqen);
      chk("R10 readback vs model", rd_data, exp_rd(rd_addr));
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdchk(string tag, int a, int exp);
    rd_addr = 4'(a);
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    int v;
    int dseq[4] = '{1, 0, 4, 3};
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    rdchk("R1 ctrl after reset", 0, 0);
    rdchk("R1 count after reset", 4, 0);
    chk("R1 pwm after reset", pwm, 0);
    chk("R1 irq after reset", irq, 0);

    wr(5, 4); wr(6, 2); wr(7, 0); wr(8, 5); wr(9, 3); wr(1, 'hF); wr(2, 1);
    rdchk("R5 period held while stopped", 5, 0);
    wr(0, 1);
    step();
    rdchk("R5 period loaded at wrap", 5, 4);
    rdchk("R6 compare loaded at wrap", 6, 2);
    rdchk("R2 count at start", 4, 0);
    for (int k = 1; k <= 10; k++) begin
      step();
      rdchk("R2 up count", 4, k % 5);
      chk("R7 duty pattern", pwm, {(k % 5) < 3, 1'b1, 1'b0, (k % 5) < 2});
    end
    chk("R8 irq only on enabled channel", irq, 1);

    wr(0, 0);
    rd_addr = 4; #1; v = rd_data;
    step();
    rdchk("R4 count frozen when stopped", 4, v);
    wr(3, 'hE);
    chk("R9 zero bits keep flag", irq, 1);
    wr(3, 1);
    chk("R9 one bit clears flag", irq, 0);

    wr(4, 2); wr(0, 3);
    rdchk("R3 count before down run", 4, 2);
    for (int k = 0; k < 4; k++) begin
      step();
      rdchk("R3 down count and reload", 4, dseq[k]);
    end

    wr(0, 0); wr(4, 0); wr(0, 9);
    for (int k = 1; k <= 8; k++) begin
      step();
      rdchk("R4 divide-by-4 pacing", 4, k / 4);
    end
    wr(5, 7);
    rdchk("R5 period held mid-cycle", 5, 4);
    wr(6, 1);
    rdchk("R6 compare held mid-cycle", 6, 2);
    repeat (20) step();
    rdchk("R5 new period after wrap", 5, 7);
    rdchk("R6 new compare after wrap", 6, 1);
    wr(1, 0);
    chk("R7 disabled channels low", pwm, 0);
    wr(1, 'hF); wr(2, 'hF);

    for (int n = 0; n < 4000; n++) begin
      int a;
      @(negedge clk);
      rd_addr = 4'($urandom_range(0, 9));
      if ($urandom_range(0, 7) == 0) begin
        a = $urandom_range(0, 9);
        wr_en = 1'b1;
        wr_addr = 4'(a);
        case (a)
          0: wr_data = 16'($urandom_range(0, 15) | ($urandom_range(0, 3) != 0 ? 1 : 0));
          4: wr_data = 16'($urandom_range(0, 25));
          5: wr_data = 16'($urandom_range(0, 20));
          6, 7, 8, 9: wr_data = 16'($urandom_range(0, 22));
          default: wr_data = 16'($urandom_range(0, 15));
        endcase
      end else
        wr_en = 1'b0;
    end
    @(negedge clk);
    wr_en = 1'b0;
    step();
    done = 1;
    summary();
    $finish;
  end
endmodule